// File: doc/BRIEF.md
# Write-Completion Acknowledge Poller

After a host finishes writing to a serial EEPROM and issues STOP, the memory starts an internal programming cycle. During that cycle it ignores the bus. This block lets the host find out when the memory is ready again. The alternative is to wait the full worst-case programming time every time.

The block repeatedly sends a START followed by the device address with the direction bit cleared, until the memory acknowledges. The acknowledged address byte is then kept as the first byte of the next queued operation. The block goes straight on to the part of that operation that follows it:

- For a write, it sends the byte address.
- For a random read, it sends the byte address and then a repeated START.
- When nothing is queued, it releases the bus with STOP.

Failed attempts are separated by a STOP and a programmable idle gap. A bounded attempt count ends a run that never gets an acknowledge.

The block drives a byte-level bus engine through a single command channel. Each command is held until the engine reports completion. For byte writes, the engine returns the acknowledge bit along with that completion. The data phases of the next operation belong to the caller.

Top module: `ack_poll_seq`

## Requirements
- R1: After reset, busy, bus_cmd_valid, op_done and timeout are 0 and attempts is 0.
- R2: A go pulse while idle captures next_op, dev_addr, byte_addr and gap_len, clears timeout and attempts, and issues a START (bus_cmd = 0) in the next cycle. A go pulse while busy has no effect on the command sequence.
- R3: Each poll attempt is a START followed by a byte write (bus_cmd = 2) of {dev_addr, 1'b0}. attempts increments when each attempt's START completes.
- R4: A probe that completes with bus_ack = 0 is followed by a STOP (bus_cmd = 1). After that, bus_cmd_valid stays low for exactly gap_len + 1 cycles, and then the next START is issued.
- R5: When a probe is acknowledged and next_op = 0 (write), the next command is a byte write of byte_addr with no further device address. op_done then pulses once that byte completes.
- R6: When a probe is acknowledged and next_op = 1 (random read), the block writes byte_addr, then issues a START, then pulses op_done.
- R7: When a probe is acknowledged and next_op is 2 or 3 (nothing queued), the block issues a STOP and then pulses op_done.
- R8: If attempt number MAX_TRIES is also refused, the block issues a STOP and returns to idle with timeout = 1, attempts = MAX_TRIES, and no op_done pulse.
- R9: While bus_cmd_valid is high and bus_done is low, bus_cmd_valid, bus_cmd and bus_wdata hold their values.
- R10: op_done lasts exactly one cycle. timeout stays set until the next accepted go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start polling (a write has just ended with STOP) |
| next_op | input | 2 | Queued operation: 0 write, 1 random read, 2/3 none |
| dev_addr | input | 7 | 7-bit device address |
| byte_addr | input | 8 | Byte address of the queued operation |
| gap_len | input | GAP_W | Idle cycles added between attempts |
| bus_cmd_valid | output | 1 | Command request to the byte engine |
| bus_cmd | output | 2 | 0 START, 1 STOP, 2 write byte |
| bus_wdata | output | 8 | Byte to write |
| bus_done | input | 1 | Engine finished the current command |
| bus_ack | input | 1 | Acknowledge bit of a finished byte write |
| busy | output | 1 | Sequence in progress |
| op_done | output | 1 | One-cycle pulse on handover to the queued operation |
| timeout | output | 1 | Sticky: attempt limit reached without acknowledge |
| attempts | output | CW | Poll attempts used in the current or last run |

## Verification
The bench refuses a chosen number of probes and checks every command in order against an expected list. The checks cover three kinds of fault:
- Retry spacing: a design that miscounts the idle gap shifts the next START, so the measured idle run would differ from gap_len + 1.
- Handover: a design that re-sends the device address after the acknowledge, or that forgets the repeated START for reads, produces an extra or a missing command.
- Attempt limit: the bench drives the attempt limit exactly. A limit that is off by one shows up as a ninth probe or a short run, together with a wrong attempts value. A timeout that is never cleared is caught by the run that follows it. A go pulse injected in the middle of a run catches a design that restarts while busy.

// File: rtl/ack_poll_seq.sv
module ack_poll_seq #(
  parameter int MAX_TRIES = 8,
  parameter int GAP_W     = 8,
  localparam int CW       = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [1:0]       next_op,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       byte_addr,
  input  logic [GAP_W-1:0] gap_len,
  output logic             bus_cmd_valid,
  output logic [1:0]       bus_cmd,
  output logic [7:0]       bus_wdata,
  input  logic             bus_done,
  input  logic             bus_ack,
  output logic             busy,
  output logic             op_done,
  output logic             timeout,
  output logic [CW-1:0]    attempts
);
  localparam logic [1:0] CMD_START = 2'd0, CMD_STOP = 2'd1, CMD_WRITE = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_PSTART, S_PDEV, S_PSTOP, S_GAP, S_ADDR, S_RSTART, S_ESTOP, S_FSTOP
  } st_t;

  st_t              st;
  logic [1:0]       op_q;
  logic [6:0]       dev_q;
  logic [7:0]       addr_q;
  logic [GAP_W-1:0] gap_q, gcnt;

  assign busy          = (st != S_IDLE);
  assign bus_cmd_valid = busy && (st != S_GAP);

  always_comb begin
    case (st)
      S_PSTOP, S_ESTOP, S_FSTOP: bus_cmd = CMD_STOP;
      S_PDEV, S_ADDR:            bus_cmd = CMD_WRITE;
      default:                   bus_cmd = CMD_START;
    endcase
    case (st)
      S_PDEV:  bus_wdata = {dev_q, 1'b0};
      S_ADDR:  bus_wdata = addr_q;
      default: bus_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= '0;
      dev_q    <= '0;
      addr_q   <= '0;
      gap_q    <= '0;
      gcnt     <= '0;
      op_done  <= 1'b0;
      timeout  <= 1'b0;
      attempts <= '0;
    end else begin
      op_done <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          op_q     <= next_op;
          dev_q    <= dev_addr;
          addr_q   <= byte_addr;
          gap_q    <= gap_len;
          attempts <= '0;
          timeout  <= 1'b0;
          st       <= S_PSTART;
        end
        S_PSTART: if (bus_done) begin
          attempts <= attempts + 1'b1;
          st       <= S_PDEV;
        end
        S_PDEV: if (bus_done) begin
          if (bus_ack)                          st <= (op_q[1] ? S_ESTOP : S_ADDR);
          else if (attempts == CW'(MAX_TRIES))  st <= S_FSTOP;
          else                                  st <= S_PSTOP;
        end
        S_PSTOP: if (bus_done) begin
          gcnt <= gap_q;
          st   <= S_GAP;
        end
        S_GAP: begin
          if (gcnt == '0) st <= S_PSTART;
          else            gcnt <= gcnt - 1'b1;
        end
        S_ADDR: if (bus_done) begin
          if (op_q[0]) st <= S_RSTART;
          else begin
            op_done <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_RSTART, S_ESTOP: if (bus_done) begin
          op_done <= 1'b1;
          st      <= S_IDLE;
        end
        S_FSTOP: if (bus_done) begin
          timeout <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && !bus_done |=> bus_cmd_valid && $stable(bus_cmd) && $stable(bus_wdata));

  assert_first_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_cmd_valid && bus_cmd == CMD_START);

  assert_release_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid && bus_cmd == CMD_STOP && bus_done |=> !bus_cmd_valid);

  assert_attempt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= CW'(MAX_TRIES));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_done && timeout));
endmodule

// File: tb/ack_poll_seq_tb.sv
module ack_poll_seq_tb;
  localparam int MAXT = 8;
  localparam int CW = $clog2(MAXT + 1);

  logic clk = 0, rst_n = 0, go = 0;
  logic [1:0] next_op = 0;
  logic [6:0] dev_addr = 0;
  logic [7:0] byte_addr = 0, gap_len = 0;
  logic bus_cmd_valid, busy, op_done, timeout;
  logic [1:0] bus_cmd;
  logic [7:0] bus_wdata;
  logic bus_done = 0, bus_ack = 0;
  logic [CW-1:0] attempts;

  always #2 clk = ~clk;

  ack_poll_seq #(.MAX_TRIES(MAXT), .GAP_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .next_op(next_op), .dev_addr(dev_addr),
    .byte_addr(byte_addr), .gap_len(gap_len), .bus_cmd_valid(bus_cmd_valid),
    .bus_cmd(bus_cmd), .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_ack(bus_ack),
    .busy(busy), .op_done(op_done), .timeout(timeout), .attempts(attempts));

  typedef struct { int cmd; int data; int gap; string req; } item_t;
  item_t exp_q[$];
  int tests_run = 0, tests_failed = 0;
  int nack_left = 0, idle_cnt = 0, lat = 0, done_seen = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int c, input int d, input int g, input string r);
    item_t it;
    it.cmd = c; it.data = d; it.gap = g; it.req = r;
    exp_q.push_back(it);
  endtask

  // bus engine model and scoreboard monitor
  always @(negedge clk) begin
    if (op_done) done_seen++;
    if (busy && !bus_cmd_valid) idle_cnt++;
    if (bus_done) begin
      bus_done = 0;
      lat = 0;
    end else if (bus_cmd_valid) begin
      lat++;
      if (lat == 2) begin
        item_t it;
        bus_done = 1;
        bus_ack = 1;
        if (bus_cmd == 2 && bus_wdata[0] == 0 && nack_left > 0) begin
          bus_ack = 0;
          nack_left--;
        end
        if (exp_q.size() == 0) begin
          chk(0, "R3 unexpected command", int'(bus_cmd), -1);
        end else begin
          it = exp_q.pop_front();
          chk(int'(bus_cmd) == it.cmd, {it.req, " cmd"}, int'(bus_cmd), it.cmd);
          if (it.cmd == 2)
            chk(int'(bus_wdata) == it.data, {it.req, " data"}, int'(bus_wdata), it.data);
          if (it.gap >= 0)
            chk(idle_cnt == it.gap, "R4 idle gap", idle_cnt, it.gap);
        end
        idle_cnt = 0;
      end
    end
  end

  task automatic run_op(input int op, input int nacks, input int gap, input int dev,
                        input int addr, input bit poke);
    int tries;
    done_seen = 0;
    tries = (nacks >= MAXT) ? MAXT : nacks + 1;
    for (int i = 0; i < tries; i++) begin
      push(0, 0, (i == 0) ? -1 : gap + 1, "R3 start");
      push(2, dev * 2, -1, "R3 probe");
      if (i < tries - 1) push(1, 0, -1, "R4 stop");
    end
    if (nacks >= MAXT) push(1, 0, -1, "R8 final stop");
    else if (op == 0) push(2, addr, -1, "R5 addr");
    else if (op == 1) begin
      push(2, addr, -1, "R6 addr");
      push(0, 0, -1, "R6 restart");
    end else push(1, 0, -1, "R7 stop");
    nack_left = nacks;
    @(negedge clk);
    next_op = 2'(op); dev_addr = 7'(dev); byte_addr = 8'(addr); gap_len = 8'(gap); go = 1;
    @(negedge clk);
    go = 0;
    chk(busy && bus_cmd_valid && bus_cmd == 0, "R2 start issued", int'(bus_cmd), 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      next_op = 2; dev_addr = 7'h7F; byte_addr = 8'hFF; go = 1;
      @(negedge clk);
      go = 0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 sequence complete", exp_q.size(), 0);
    exp_q.delete();
    chk(int'(attempts) == tries, "R3 attempts", int'(attempts), tries);
    if (nacks >= MAXT) begin
      chk(timeout == 1, "R8 timeout set", int'(timeout), 1);
      chk(done_seen == 0, "R8 no done", done_seen, 0);
    end else begin
      chk(timeout == 0, "R10 timeout clear", int'(timeout), 0);
      chk(done_seen == 1, "R10 single done pulse", done_seen, 1);
    end
    chk(!bus_cmd_valid, "R2 idle after run", int'(bus_cmd_valid), 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !bus_cmd_valid && !op_done && !timeout && attempts == 0,
        "R1 reset state", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_cmd_valid, "R1 idle after reset", int'(bus_cmd_valid), 0);
    run_op(0, 0, 3, 7'h50, 8'h21, 0);    // R5 immediate ack
    run_op(0, 2, 3, 7'h51, 8'h33, 1);    // R4 retries, R2 busy go ignored
    run_op(1, 1, 0, 7'h52, 8'h45, 0);    // R6 random read, zero gap
    run_op(2, 0, 2, 7'h53, 8'h57, 0);    // R7 nothing queued
    run_op(3, 3, 5, 7'h2A, 8'h69, 0);    // R7 op 3, longer gap
    run_op(0, 100, 1, 7'h54, 8'h7B, 0);  // R8 timeout
    run_op(0, 0, 0, 7'h55, 8'h8D, 0);    // R10 timeout cleared by next go
    run_op(1, MAXT - 1, 2, 7'h56, 8'h9F, 0); // R8 ack on last allowed attempt
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule